// File: doc/BRIEF.md
# Card Flash Program and Erase Sequencer

This block sits on the host side of a 16-bit removable flash card socket. A single start pulse, with an operation code, a card byte address and a 16-bit data word, makes it issue the complete unlock-and-command write sequence that the card's paired byte-wide flash devices expect. The same command byte goes to both devices at once, as a duplicated word. Every write and read strobe is stretched to meet the card's nanosecond minimums, which are turned into clock counts from a clock-period parameter.

After the command phase the sequencer polls the target word. It judges the even device (data bits 7..0) and the odd device (data bits 15..8) separately, using the completion-bit and time-limit-bit algorithm. It finishes with one confirming read, or with a failure code for each lane. The card data bus is presented as separate outgoing data, an output-enable flag and incoming data, so the pad ring can build the tristate driver.

**Operations and command sequences**

Operation codes are 0 reset-to-read, 1 word program, 2 sector erase and 3 whole-device erase. The chip-side command addresses are 5555h and 2AAAh. Each becomes the card address (chip address × 2) plus the base of the 1 MiB device pair that holds the target, with bit 0 zero.

**States**

The states are IDLE, WSU (address and data set up), WLO (write strobe low), WHD (hold), RD (read wait), GAP (output enable high between reads), SETTLE (confirming read) and FIN (one-cycle report).

**Transitions**

- IDLE→WSU on start.
- WSU→WLO→WHD as each counter runs out.
- WHD→WSU for the next command step.
- WHD→FIN after the single reset write.
- WHD→RD after the last write of any other operation.
- RD→GAP after the read wait, sampling the bus.
- GAP→RD while a lane is unresolved and the poll limit is not reached.
- GAP→SETTLE when both lanes passed.
- GAP→FIN when both lanes are resolved with a failure, or when the poll limit is reached.
- SETTLE→FIN.
- FIN→IDLE.

Top module: `pcfs_flash_seq`

## Requirements
- R1: Word program issues exactly four writes. The first three are AAAAh at pair base + AAAAh, 5555h at pair base + 5554h, and A0A0h at pair base + AAAAh. The fourth is the data word at the target address with bit 0 cleared. The pair base is the target address with its low PAIR_AW bits cleared.
- R2: Sector erase issues six writes: AAAAh, 5555h, 8080h, AAAAh and 5555h at the same two unlock addresses, then 3030h at the target. Whole-device erase is identical except that the sixth write is 1010h at pair base + AAAAh.
- R3: Reset (op 0) issues a single F0F0h write at the target. It then reports done with no read and no failure.
- R4: During every write both card enables are low and output enable is high. Address and data are stable at least ceil(20/CLK_NS) cycles before the write strobe falls. The strobe stays low at least ceil(120/CLK_NS) cycles. Address and data are held, and still driven, at least ceil(30/CLK_NS) cycles after it rises.
- R5: Every read holds output enable low at least ceil(125/CLK_NS) cycles, with the bus not driven. Every read uses the target address with bit 0 cleared, including during whole-device erase.
- R6: A lane passes when its completion bit (bit 7 of its byte) equals the expected value. The expected value is bit 7 (even lane) or bit 15 (odd lane) of the program data, or 1 for an erase. When both lanes pass, one further confirming read is made and done rises without fail.
- R7: A lane whose completion bit mismatches while its time-limit bit (bit 5 of its byte) is 1 is read once more. It passes if the completion bit now matches; otherwise its lane code becomes 01 and fail is reported.
- R8: If a lane is still unresolved after POLL_LIMIT reads, polling stops and that lane's code becomes 10. No confirming read follows.
- R9: busy is high from the cycle after start until done. done is a one-cycle pulse. fail equals done qualified by a nonzero fail_code. fail_code holds its value until the next accepted start.
- R10: A start pulse while busy is ignored, with the operation, address and data of the running operation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | 0 reset, 1 program, 2 sector erase, 3 device erase |
| addr | input | ADDR_W | Target card byte address |
| wdata | input | 16 | Program data word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Failure, valid with done |
| fail_code | output | 4 | Bits 1:0 even lane, 3:2 odd lane: 00 ok, 01 time limit, 10 poll limit |
| card_addr | output | ADDR_W | Card address bus |
| ce1_n | output | 1 | Even byte enable, active low |
| ce2_n | output | 1 | Odd byte enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write strobe, active low |
| bus_out | output | 16 | Data driven to the card |
| bus_oe | output | 1 | Drive enable for bus_out |
| bus_in | input | 16 | Data returned by the card |

## Verification
The bench builds the block with CLK_NS = 4, ADDR_W = 21 (two device pairs), PAIR_AW = 20 and POLL_LIMIT = 6. Six reads make the poll-limit path short enough that every combination of four lane behaviours can be swept for each lane. The four behaviours are clean finish, finish on the time-limit re-read, time-limit failure and never finishing. The sweep covers word program with four data words spanning both completion-bit values per lane, and sector erase, across both device pairs. With a 4 ns period every timing minimum maps to a distinct cycle count, so each strobe width, setup and hold is measured exactly.

// File: rtl/pcfs_pkg.sv
package pcfs_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_PROG  = 2'd1,
        OP_SECT  = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WSU,
        S_WLO,
        S_WHD,
        S_RD,
        S_GAP,
        S_SETTLE,
        S_FIN
    } state_e;

    // One command write: where it goes and what it carries
    typedef struct packed {
        logic        at_target;
        logic        with_data;
        logic [15:0] chip_a;
        logic [7:0]  code;
    } step_t;

    localparam logic [15:0] UNLOCK_A = 16'h5555;
    localparam logic [15:0] UNLOCK_B = 16'h2AAA;

    localparam logic [1:0] LF_NONE = 2'b00;
    localparam logic [1:0] LF_TLE  = 2'b01;
    localparam logic [1:0] LF_WDOG = 2'b10;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic logic [2:0] step_count(op_e op);
        case (op)
            OP_RESET: return 3'd1;
            OP_PROG:  return 3'd4;
            default:  return 3'd6;
        endcase
    endfunction

    function automatic step_t step_of(op_e op, logic [2:0] idx);
        step_t s;
        s.at_target = 1'b0;
        s.with_data = 1'b0;
        s.chip_a    = UNLOCK_A;
        s.code      = 8'hAA;
        if (op == OP_RESET) begin
            s.at_target = 1'b1;
            s.code      = 8'hF0;
        end else begin
            case (idx)
                3'd1, 3'd4: begin
                    s.chip_a = UNLOCK_B;
                    s.code   = 8'h55;
                end
                3'd2: s.code = (op == OP_PROG) ? 8'hA0 : 8'h80;
                3'd3: begin
                    if (op == OP_PROG) begin
                        s.at_target = 1'b1;
                        s.with_data = 1'b1;
                    end
                end
                3'd5: begin
                    if (op == OP_SECT) begin
                        s.at_target = 1'b1;
                        s.code      = 8'h30;
                    end else begin
                        s.code = 8'h10;
                    end
                end
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pcfs_cmd_gen.sv
module pcfs_cmd_gen
    import pcfs_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int PAIR_AW = 20
) (
    input  op_e               op,
    input  logic [2:0]        idx,
    input  logic [ADDR_W-1:0] tgt,
    input  logic [15:0]       wdata,
    output logic [ADDR_W-1:0] bus_a,
    output logic [15:0]       bus_d
);
    step_t             st;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] cmd_a;

    assign st    = step_of(op, idx);
    // Device-pair base: target with the in-pair offset removed
    assign base  = {tgt[ADDR_W-1:PAIR_AW], {PAIR_AW{1'b0}}};
    assign cmd_a = base | ADDR_W'({st.chip_a, 1'b0});
    assign bus_a = st.at_target ? {tgt[ADDR_W-1:1], 1'b0} : cmd_a;
    assign bus_d = st.with_data ? wdata : {st.code, st.code};
endmodule

// File: rtl/pcfs_lane_judge.sv
module pcfs_lane_judge
    import pcfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       sample,
    input  logic [7:0] lane_byte,
    input  logic       exp7,
    input  logic       wd_hit,
    output logic       resolved,
    output logic       passed,
    output logic [1:0] code
);
    logic rechk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resolved <= 1'b0;
            passed   <= 1'b0;
            rechk    <= 1'b0;
            code     <= LF_NONE;
        end else if (arm) begin
            resolved <= 1'b0;
            passed   <= 1'b0;
            rechk    <= 1'b0;
            code     <= LF_NONE;
        end else if (!resolved) begin
            if (sample) begin
                if (lane_byte[7] == exp7) begin
                    resolved <= 1'b1;
                    passed   <= 1'b1;
                end else if (rechk) begin
                    resolved <= 1'b1;
                    code     <= LF_TLE;
                end else if (lane_byte[5]) begin
                    rechk <= 1'b1;
                end
            end else if (wd_hit) begin
                resolved <= 1'b1;
                code     <= LF_WDOG;
            end
        end
    end
endmodule

// File: rtl/pcfs_flash_seq.sv
module pcfs_flash_seq
    import pcfs_pkg::*;
#(
    parameter int CLK_NS     = 4,
    parameter int ADDR_W     = 23,
    parameter int PAIR_AW    = 20,
    parameter int POLL_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [3:0]        fail_code,
    output logic [ADDR_W-1:0] card_addr,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [15:0]       bus_out,
    output logic              bus_oe,
    input  logic [15:0]       bus_in
);
    localparam int unsigned T_SU   = ns_to_cyc(20, CLK_NS);
    localparam int unsigned T_WLB  = ns_to_cyc(120, CLK_NS);
    localparam int unsigned T_HD   = ns_to_cyc(30, CLK_NS);
    localparam int unsigned T_CYC  = ns_to_cyc(200, CLK_NS);
    localparam int unsigned T_REST = (T_CYC > T_SU + T_HD) ? (T_CYC - T_SU - T_HD) : 1;
    localparam int unsigned T_WL   = (T_WLB > T_REST) ? T_WLB : T_REST;
    localparam int unsigned T_RD   = ns_to_cyc(200, CLK_NS);
    localparam int unsigned T_OE   = ns_to_cyc(125, CLK_NS);
    localparam int unsigned T_GAP  = ns_to_cyc(20, CLK_NS);
    localparam int unsigned T_MAX  = (T_RD > T_WL) ? T_RD : T_WL;
    localparam int          CNT_W  = $clog2(T_MAX + 1);
    localparam int          PW     = $clog2(POLL_LIMIT + 1);

    state_e            state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        step;
    logic [PW-1:0]     polls;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;

    logic              arm, sample, wd_hit, final_step;
    logic [1:0]        res, pas, exp7;
    logic [1:0]        lcode [2];
    logic [ADDR_W-1:0] gen_a;
    logic [15:0]       gen_d;

    pcfs_cmd_gen #(.ADDR_W(ADDR_W), .PAIR_AW(PAIR_AW)) u_gen (
        .op   (op_q),
        .idx  (step),
        .tgt  (addr_q),
        .wdata(wdata_q),
        .bus_a(gen_a),
        .bus_d(gen_d)
    );

    assign exp7[0] = (op_q == OP_PROG) ? wdata_q[7]  : 1'b1;
    assign exp7[1] = (op_q == OP_PROG) ? wdata_q[15] : 1'b1;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        pcfs_lane_judge u_judge (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm),
            .sample   (sample),
            .lane_byte(bus_in[8*g +: 8]),
            .exp7     (exp7[g]),
            .wd_hit   (wd_hit),
            .resolved (res[g]),
            .passed   (pas[g]),
            .code     (lcode[g])
        );
    end

    assign final_step = (step == step_count(op_q) - 3'd1);

    // Next state and control pulses
    always_comb begin
        nxt    = state;
        arm    = 1'b0;
        sample = 1'b0;
        wd_hit = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nxt = S_WSU;
                    arm = 1'b1;
                end
            end
            S_WSU:  if (cnt == CNT_W'(T_SU - 1)) nxt = S_WLO;
            S_WLO:  if (cnt == CNT_W'(T_WL - 1)) nxt = S_WHD;
            S_WHD: begin
                if (cnt == CNT_W'(T_HD - 1)) begin
                    if (!final_step)            nxt = S_WSU;
                    else if (op_q == OP_RESET)  nxt = S_FIN;
                    else                        nxt = S_RD;
                end
            end
            S_RD: begin
                if (cnt == CNT_W'(T_RD - 1)) begin
                    nxt    = S_GAP;
                    sample = 1'b1;
                end
            end
            S_GAP: begin
                if (cnt == CNT_W'(T_GAP - 1)) begin
                    if (&res) begin
                        nxt = (&pas) ? S_SETTLE : S_FIN;
                    end else if (polls == PW'(POLL_LIMIT)) begin
                        nxt    = S_FIN;
                        wd_hit = 1'b1;
                    end else begin
                        nxt = S_RD;
                    end
                end
            end
            S_SETTLE: if (cnt == CNT_W'(T_OE - 1)) nxt = S_FIN;
            S_FIN:    nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register, counters and operation latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            step    <= '0;
            polls   <= '0;
            op_q    <= OP_RESET;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
            if (state == S_IDLE && start) begin
                op_q    <= op_e'(op);
                addr_q  <= addr;
                wdata_q <= wdata;
                step    <= '0;
                polls   <= '0;
            end
            if (state == S_WHD && nxt == S_WSU) step <= step + 3'd1;
            if (sample) polls <= polls + 1'b1;
        end
    end

    // Card strobes and host status from the state
    always_comb begin
        ce1_n     = 1'b1;
        ce2_n     = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        bus_oe    = 1'b0;
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
        fail_code = {lcode[1], lcode[0]};
        fail      = (state == S_FIN) && (fail_code != 4'd0);
        bus_out   = gen_d;
        card_addr = gen_a;
        unique case (state)
            S_WSU, S_WHD: begin
                ce1_n  = 1'b0;
                ce2_n  = 1'b0;
                bus_oe = 1'b1;
            end
            S_WLO: begin
                ce1_n  = 1'b0;
                ce2_n  = 1'b0;
                we_n   = 1'b0;
                bus_oe = 1'b1;
            end
            S_RD, S_SETTLE: begin
                ce1_n     = 1'b0;
                ce2_n     = 1'b0;
                oe_n      = 1'b0;
                card_addr = {addr_q[ADDR_W-1:1], 1'b0};
            end
            S_GAP: begin
                ce1_n     = 1'b0;
                ce2_n     = 1'b0;
                card_addr = {addr_q[ADDR_W-1:1], 1'b0};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcfs_flash_seq_chk.sv
module pcfs_flash_seq_chk
    import pcfs_pkg::*;
#(
    parameter int CLK_NS = 4,
    parameter int ADDR_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              bus_oe,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [15:0]       bus_out,
    input logic [ADDR_W-1:0] card_addr
);
    localparam int unsigned MIN_WL = ns_to_cyc(120, CLK_NS);
    localparam int unsigned MIN_HD = ns_to_cyc(30, CLK_NS);
    localparam int          MW     = $clog2(MIN_WL + MIN_HD + 2);

    logic [MW-1:0] wl_seen;
    logic [MW-1:0] hd_since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_seen  <= '0;
            hd_since <= MW'(MIN_HD);
        end else begin
            if (!we_n) wl_seen <= (wl_seen == {MW{1'b1}}) ? wl_seen : wl_seen + 1'b1;
            else       wl_seen <= '0;
            if (!we_n)                   hd_since <= '0;
            else if (hd_since < MW'(MIN_HD)) hd_since <= hd_since + 1'b1;
        end
    end

    a_r4_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    a_r4_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (bus_oe && !ce1_n && !ce2_n));

    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (wl_seen >= MW'(MIN_WL)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && hd_since < MW'(MIN_HD)) |-> ($stable(card_addr) && $stable(bus_out) && bus_oe));

    a_r5_read_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !bus_oe);

    a_r9_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind pcfs_flash_seq pcfs_flash_seq_chk #(.CLK_NS(CLK_NS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .bus_oe   (bus_oe),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .bus_out  (bus_out),
    .card_addr(card_addr)
);

// File: tb/tb_pcfs_flash_seq.sv
module tb_pcfs_flash_seq;
    localparam int CLK_NS = 4;
    localparam int AW     = 21;
    localparam int PLIM   = 6;
    localparam int MIN_SU = (20 + CLK_NS - 1) / CLK_NS;
    localparam int MIN_WL = (120 + CLK_NS - 1) / CLK_NS;
    localparam int MIN_HD = (30 + CLK_NS - 1) / CLK_NS;
    localparam int MIN_OE = (125 + CLK_NS - 1) / CLK_NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic          busy, done, fail, ce1_n, ce2_n, oe_n, we_n, bus_oe;
    logic [3:0]    fail_code;
    logic [AW-1:0] card_addr;
    logic [15:0]   bus_out, bus_in;

    pcfs_flash_seq #(.CLK_NS(CLK_NS), .ADDR_W(AW), .PAIR_AW(20), .POLL_LIMIT(PLIM)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .fail(fail), .fail_code(fail_code),
        .card_addr(card_addr), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    always #2 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    // Card model: lane behaviour 0 clean, 1 finish on time-limit re-read, 2 time-limit fail, 3 never
    int          mode_e = 0, mode_o = 0, nb_e = 1, nb_o = 1;
    int          rdn = 0;
    logic        x7_e = 1'b1, x7_o = 1'b1;
    logic [7:0]  fin_e = 8'hFF, fin_o = 8'hFF;

    function automatic logic [7:0] lane_byte(int m, int n, int r, logic x7, logic [7:0] fin);
        int k;
        k = r + 1;
        case (m)
            0: return (k <= n) ? {~x7, 7'h00} : fin;
            1: return (k < n) ? {~x7, 7'h00} : (k == n) ? {~x7, 2'b01, 5'h00} : fin;
            2: return {~x7, 2'b01, 5'h00};
            default: return {~x7, 7'h00};
        endcase
    endfunction

    always_comb begin
        if (oe_n) bus_in = 16'h0000;
        else bus_in = {lane_byte(mode_o, nb_o, rdn, x7_o, fin_o),
                       lane_byte(mode_e, nb_e, rdn, x7_e, fin_e)};
    end

    // Bus monitors
    logic [AW-1:0] w_a [8];
    logic [15:0]   w_d [8];
    int            wn = 0, tim_err = 0, rd_err = 0;
    logic [AW-1:0] tgt_exp = '0;
    logic          p_we = 1'b1, p_oe = 1'b1, p_boe = 1'b0;
    logic [AW-1:0] p_a = '0;
    logic [15:0]   p_d = '0;
    int            wl_run = 0, su_run = 0, hd_since = 100, ol_run = 0;

    always @(negedge clk) begin
        logic chg;
        chg = (card_addr != p_a) || (bus_out != p_d) || !bus_oe;
        su_run = chg ? 0 : su_run + 1;
        if (!we_n) begin
            if (p_we && su_run < MIN_SU) tim_err++;
            wl_run++;
        end else begin
            hd_since++;
            if (!p_we) begin
                if (wl_run < MIN_WL) tim_err++;
                if (ce1_n || ce2_n || !oe_n) tim_err++;
                if (wn < 8) begin
                    w_a[wn] = card_addr;
                    w_d[wn] = bus_out;
                end
                wn++;
                hd_since = 1;
            end
            if (p_boe && chg && hd_since <= MIN_HD) tim_err++;
            wl_run = 0;
        end
        if (!oe_n) ol_run++;
        else begin
            if (!p_oe) begin
                if (ol_run < MIN_OE) rd_err++;
                if (card_addr != tgt_exp || bus_oe) rd_err++;
                rdn++;
            end
            ol_run = 0;
        end
        p_we = we_n; p_oe = oe_n; p_a = card_addr; p_d = bus_out; p_boe = bus_oe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void exp_wr(input logic [1:0] o, input int i, input logic [AW-1:0] a,
                                   input logic [15:0] d, output logic [AW-1:0] ea,
                                   output logic [15:0] ed);
        logic [AW-1:0] base, t, ua, ub;
        base = {a[AW-1], 20'h0};
        t    = {a[AW-1:1], 1'b0};
        ua   = base + 21'h0AAAA;
        ub   = base + 21'h05554;
        if (o == 2'd0) begin ea = t; ed = 16'hF0F0; return; end
        case (i)
            0, 3: begin ea = ua; ed = 16'hAAAA; end
            1, 4: begin ea = ub; ed = 16'h5555; end
            2: begin ea = ua; ed = (o == 2'd1) ? 16'hA0A0 : 16'h8080; end
            default: begin ea = ua; ed = 16'h1010; end
        endcase
        if (o == 2'd1 && i == 3) begin ea = t; ed = d; end
        if (o == 2'd2 && i == 5) begin ea = t; ed = 16'h3030; end
    endfunction

    function automatic int lane_end(int m, int n);
        return (m <= 1) ? n + 1 : (m == 2) ? 2 : 1000;
    endfunction

    function automatic logic [1:0] lane_code(int m);
        return (m <= 1) ? 2'b00 : (m == 2) ? 2'b01 : 2'b10;
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [AW-1:0] a, input logic [15:0] d,
                          input int me, input int mo, input int ne, input int no, input bit poke);
        string         rq, rc;
        int            cyc, nw, polls, exp_rd;
        logic [3:0]    ecode;
        logic [AW-1:0] ea;
        logic [15:0]   ed;
        bit            wok;
        rq = (o == 2'd0) ? "R3" : (o == 2'd1) ? "R1" : "R2";
        mode_e = me; mode_o = mo; nb_e = ne; nb_o = no;
        x7_e  = (o == 2'd1) ? d[7]  : 1'b1;
        x7_o  = (o == 2'd1) ? d[15] : 1'b1;
        fin_e = (o == 2'd1) ? d[7:0]  : 8'hFF;
        fin_o = (o == 2'd1) ? d[15:8] : 8'hFF;
        @(negedge clk);
        wn = 0; rdn = 0; tim_err = 0; rd_err = 0;
        tgt_exp = {a[AW-1:1], 1'b0};
        op = o; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 100) begin
                start = 1'b1; op = ~o; addr = ~a; wdata = ~d;   // R10 stimulus
            end else start = 1'b0;
        end
        start = 1'b0;
        chk(done == 1'b1, rq, "done reached", done, 1);
        if (o == 2'd0) begin
            ecode = 4'd0; polls = 0; exp_rd = 0;
        end else begin
            ecode = {lane_code(mo), lane_code(me)};
            polls = (lane_end(me, ne) > lane_end(mo, no)) ? lane_end(me, ne) : lane_end(mo, no);
            if (polls > PLIM) polls = PLIM;
            exp_rd = polls + ((ecode == 4'd0) ? 1 : 0);
        end
        rc = (me == 3 || mo == 3) ? "R8" : (me >= 1 || mo >= 1) ? "R7" : "R6";
        if (o == 2'd0) rc = "R3";
        chk(fail_code == ecode, rc, "fail_code", fail_code, ecode);
        chk(fail == (ecode != 4'd0), rc, "fail with done", fail, ecode != 4'd0);
        nw = (o == 2'd0) ? 1 : (o == 2'd1) ? 4 : 6;
        chk(wn == nw, rq, "write count", wn, nw);
        wok = 1'b1;
        for (int i = 0; i < nw && i < wn; i++) begin
            exp_wr(o, i, a, d, ea, ed);
            if (w_a[i] != ea || w_d[i] != ed) begin
                wok = 1'b0;
                chk(1'b0, poke ? "R10" : rq, "write addr/data", {w_a[i], w_d[i]}, {ea, ed});
            end
        end
        if (wok) chk(1'b1, rq, "writes", 0, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done one cycle, idle", {done, busy}, 0);
        chk(fail_code == ecode, "R9", "fail_code held", fail_code, ecode);
        chk(rdn == exp_rd, rc, "read count", rdn, exp_rd);
        chk(rd_err == 0, "R5", "read timing/address errors", rd_err, 0);
        chk(tim_err == 0, "R4", "write timing errors", tim_err, 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'h1234; pats[1] = 16'h80FF; pats[2] = 16'h7F80; pats[3] = 16'hA55A;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && fail == 0 && fail_code == 0, "R9", "reset status",
            {busy, done, fail, fail_code}, 0);
        chk(we_n && oe_n && ce1_n && ce2_n && !bus_oe, "R4", "reset strobes",
            {we_n, oe_n, ce1_n, ce2_n, bus_oe}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_op(2'd0, 21'h012344, 16'h0, 0, 0, 1, 1, 1'b0);
        run_op(2'd0, 21'h1ABCDF, 16'h0, 0, 0, 1, 1, 1'b0);
        for (int p = 0; p < 4; p++)
            for (int me = 0; me < 4; me++)
                for (int mo = 0; mo < 4; mo++)
                    run_op(2'd1, AW'(21'h023456 + p * 21'h0811F1 + me * 21'h2221 + mo * 21'h151),
                           pats[p], me, mo, 2, 4, 1'b0);
        for (int me = 0; me < 4; me++)
            for (int mo = 0; mo < 4; mo++)
                run_op(2'd2, AW'(21'h0F0001 + me * 21'h80000 + mo * 21'h10000), 16'h0,
                       me, mo, 4, 1, 1'b0);
        for (int m = 0; m < 4; m++)
            run_op(2'd3, AW'(21'h133331 + m * 21'h2F0000), 16'h0, m, 3 - m, 3, 2, 1'b0);
        run_op(2'd1, 21'h1FFFFE, 16'hC3A5, 1, 0, 3, 2, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule